// File: doc/BRIEF.md
# HDLC Command-Driven Serial Transmitter

This block is the transmit half of a bit-oriented link controller. A host writes payload bytes into a 32-entry transmit queue and then writes a command. The command either starts a framed transfer, starts a raw (transparent) transfer, marks the bytes already queued as the end of the message, or resets the transmitter. The block drives one line bit for each cycle in which `bit_en` is high. When no frame is being sent it fills the line with flags. It also provides a command-busy status and a one-cycle pool-ready interrupt pulse.

A framed transfer begins with a flag. The payload follows, least significant bit first, with a 0 inserted after every run of five 1s. A complemented CRC-16 and a closing flag end the frame. A long message goes out as several blocks. The interrupt asks for each next block as soon as the queue drains, while the frame is still open. A command is held in a one-entry slot until the next `bit_en` cycle. While it waits, `cmd_busy` is high and further commands are refused. A reset command empties the queue, sends seven 1s as an abort pattern and then returns to flag fill. It can cut off a frame in mid-transfer.

The engine has five states:
- FILL sends flags.
- DATA sends stuffed payload.
- CRC sends the stuffed check sequence.
- TRANSP sends raw payload.
- ABORT sends the seven 1s.

The transitions are as follows:
- FILL goes to DATA or TRANSP at a flag boundary, once a start is pending and the queue holds data.
- DATA loops over bytes while data remains.
- DATA goes to CRC at a byte boundary when the queue is empty and the end mark is set.
- DATA or TRANSP goes to ABORT when the queue is empty and no end mark is set (underrun).
- CRC returns to FILL after 16 check bits.
- TRANSP returns to FILL when the queue is empty and the end mark is set.
- ABORT returns to FILL after seven bits.
- An executed reset command moves any state to ABORT.

Top module: `hdlc_cmd_tx`

## Requirements
- R1: After reset `tx_bit` is 1 and both `cmd_busy` and `pool_irq` are 0. On the following `bit_en` cycles the line carries back-to-back flags, each sent as 0,1,1,1,1,1,1,0.
- R2: The command input `cmd_sel` is encoded as follows: bit 3 is reset, bit 2 is HDLC start, bit 1 is transparent start and bit 0 is message end. A write with a nonzero `cmd_sel` while `cmd_busy` is 0 raises `cmd_busy` on the next cycle. `cmd_busy` stays high through every cycle without `bit_en`, and falls in the cycle after the first `bit_en` cycle, when the command executes. A command written while `cmd_busy` is high is discarded.
- R3: An HDLC-start frame is sent as a flag, then the queued bytes least significant bit first, then the check sequence, then a flag.
- R4: In the payload and check fields, a 0 is inserted after every five consecutive 1s.
- R5: The check sequence is the CRC-16 with polynomial x^16+x^12+x^5+1 and preset 0xFFFF, computed least significant bit first over the payload. It is sent complemented, low byte first.
- R6: A transparent-start frame sends the queued bytes raw, with no bit insertion and no check sequence, between flags.
- R7: If the queue is empty at a byte boundary of an open frame and no message end has been given, seven 1s are sent and flag fill resumes.
- R8: An executed reset command empties the queue, sends seven 1s, returns to flag fill, cancels pending start and end marks, and pulses `pool_irq` once.
- R9: `pool_irq` pulses for one cycle when the last queued byte of an open frame is taken and no message end is pending. It does not pulse when the end mark is already set.
- R10: The queue holds at most 32 bytes. Writes made while it is full are dropped.
- R11: `tx_bit` changes only in the cycle after a `bit_en` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One serial bit period elapses |
| wr_en | input | 1 | Push `wr_data` into the transmit queue |
| wr_data | input | 8 | Payload byte |
| cmd_wr | input | 1 | Write `cmd_sel` to the command slot |
| cmd_sel | input | 4 | Command bits: [3] reset, [2] HDLC start, [1] transparent start, [0] message end |
| cmd_busy | output | 1 | A written command has not yet executed |
| pool_irq | output | 1 | One-cycle pulse: queue ready for the next block |
| tx_bit | output | 1 | Serial line output |

## Verification
The bench decodes the line like a receiver: it finds flags, removes inserted zeros, detects aborts and compares each frame against CRC values it computes itself. The payloads include 0xFF and 0x7E, so a transmitter that skipped bit insertion would produce false flags or aborts. A raw transfer carries a five-1 run followed by 0, which exposes a transparent path that stuffs bits. A two-block message checks the refill interrupt, and a deliberate underrun checks the abort. A reset cut into a 20-byte frame is followed by a short frame that would carry leftover bytes if the queue were not emptied. With `bit_en` held off, the bench confirms that `cmd_busy` stays high and that a second command is dropped; a design that latched it would later raise an unexpected abort.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    typedef enum logic [2:0] {
        ST_FILL,
        ST_DATA,
        ST_CRC,
        ST_TRANSP,
        ST_ABORT
    } tx_state_t;

    // bit 3 reset, bit 2 framed start, bit 1 raw start, bit 0 end of message
    typedef struct packed {
        logic rst;
        logic frm;
        logic trn;
        logic eom;
    } cmd_t;

    localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
    localparam logic [15:0] CRC_PRESET = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_R = 16'h8408;
    localparam int          ABORT_ONES = 7;
    localparam int          STUFF_RUN  = 5;

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic fb;
        logic [15:0] r;
        fb = c[0] ^ b;
        r  = c >> 1;
        if (fb) r = r ^ CRC_POLY_R;
        return r;
    endfunction

endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 8,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    output logic [W-1:0]  head,
    output logic          empty,
    output logic          full,
    output logic [LW-1:0] level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_wr, do_rd;

    assign empty = (level == '0);
    assign full  = (level == LW'(DEPTH));
    assign do_wr = wr_en && !full && !clr;
    assign do_rd = rd_en && !empty && !clr;
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            level <= level + LW'(do_wr) - LW'(do_rd);
        end
    end
endmodule

// File: rtl/hdlc_tx_cmd.sv
module hdlc_tx_cmd
    import hdlc_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  cmd_t cmd_in,
    input  logic tick,
    output logic busy,
    output cmd_t exec
);
    cmd_t pend;

    assign busy = (pend != '0);
    assign exec = tick ? pend : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else if (tick && busy) begin
            pend <= '0;
        end else if (cmd_wr && (cmd_in != '0) && !busy) begin
            pend <= cmd_in;
        end
    end
endmodule

// File: rtl/hdlc_tx_engine.sv
module hdlc_tx_engine
    import hdlc_tx_pkg::*;
#(
    parameter int LW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  cmd_t          exec,
    input  logic [7:0]    fifo_head,
    input  logic          fifo_empty,
    input  logic [LW-1:0] fifo_level,
    output logic          fifo_pop,
    output logic          fifo_clr,
    output logic          tx_bit,
    output logic          irq
);
    tx_state_t   state, n_state;
    logic [4:0]  cnt, n_cnt;
    logic [7:0]  shreg, n_sh;
    logic [2:0]  ones, n_ones;
    logic [15:0] crc, n_crc;
    logic        go_frm, n_go_frm;
    logic        go_trn, n_go_trn;
    logic        eom, n_eom;
    logic        tx_q, n_tx;
    logic        irq_q, n_irq;
    logic        b;
    logic        stuff_now;
    logic        last_byte;

    assign stuff_now = (ones == 3'(STUFF_RUN));
    assign last_byte = (fifo_level == LW'(1)) && !eom;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_FILL;
            cnt    <= 5'd8;
            shreg  <= '0;
            ones   <= '0;
            crc    <= CRC_PRESET;
            go_frm <= 1'b0;
            go_trn <= 1'b0;
            eom    <= 1'b0;
            tx_q   <= 1'b1;
            irq_q  <= 1'b0;
        end else begin
            state  <= n_state;
            cnt    <= n_cnt;
            shreg  <= n_sh;
            ones   <= n_ones;
            crc    <= n_crc;
            go_frm <= n_go_frm;
            go_trn <= n_go_trn;
            eom    <= n_eom;
            tx_q   <= n_tx;
            irq_q  <= n_irq;
        end
    end

    // next state and outputs
    always_comb begin
        n_state  = state;
        n_cnt    = cnt;
        n_sh     = shreg;
        n_ones   = ones;
        n_crc    = crc;
        n_go_frm = go_frm;
        n_go_trn = go_trn;
        n_eom    = eom;
        n_tx     = tx_q;
        n_irq    = 1'b0;
        fifo_pop = 1'b0;
        fifo_clr = 1'b0;
        b        = 1'b0;
        if (tick) begin
            if (exec.rst) begin
                fifo_clr = 1'b1;
                n_state  = ST_ABORT;
                n_tx     = 1'b1;
                n_cnt    = 5'd1;
                n_ones   = '0;
                n_go_frm = 1'b0;
                n_go_trn = 1'b0;
                n_eom    = 1'b0;
                n_irq    = 1'b1;
            end else begin
                unique case (state)
                    ST_FILL: begin
                        if (cnt == 5'd8) begin
                            if ((go_frm || go_trn) && !fifo_empty) begin
                                fifo_pop = 1'b1;
                                n_sh     = fifo_head;
                                b        = fifo_head[0];
                                n_tx     = b;
                                n_cnt    = 5'd1;
                                n_irq    = last_byte;
                                n_go_frm = 1'b0;
                                n_go_trn = 1'b0;
                                if (go_frm) begin
                                    n_state = ST_DATA;
                                    n_crc   = crc_step(CRC_PRESET, b);
                                    n_ones  = b ? 3'd1 : 3'd0;
                                end else begin
                                    n_state = ST_TRANSP;
                                    n_ones  = '0;
                                end
                            end else begin
                                n_tx  = FLAG_BYTE[0];
                                n_cnt = 5'd1;
                            end
                        end else begin
                            n_tx  = FLAG_BYTE[cnt[2:0]];
                            n_cnt = cnt + 5'd1;
                        end
                    end
                    ST_DATA: begin
                        if (stuff_now) begin
                            n_tx   = 1'b0;
                            n_ones = '0;
                        end else if (cnt == 5'd8) begin
                            if (!fifo_empty) begin
                                fifo_pop = 1'b1;
                                n_sh     = fifo_head;
                                b        = fifo_head[0];
                                n_tx     = b;
                                n_crc    = crc_step(crc, b);
                                n_ones   = b ? ones + 3'd1 : 3'd0;
                                n_cnt    = 5'd1;
                                n_irq    = last_byte;
                            end else if (eom) begin
                                n_state = ST_CRC;
                                b       = ~crc[0];
                                n_tx    = b;
                                n_ones  = b ? ones + 3'd1 : 3'd0;
                                n_cnt   = 5'd1;
                            end else begin
                                n_state = ST_ABORT;
                                n_tx    = 1'b1;
                                n_cnt   = 5'd1;
                                n_ones  = '0;
                            end
                        end else begin
                            b      = shreg[cnt[2:0]];
                            n_tx   = b;
                            n_crc  = crc_step(crc, b);
                            n_ones = b ? ones + 3'd1 : 3'd0;
                            n_cnt  = cnt + 5'd1;
                        end
                    end
                    ST_CRC: begin
                        if (stuff_now) begin
                            n_tx   = 1'b0;
                            n_ones = '0;
                        end else if (cnt == 5'd16) begin
                            n_state = ST_FILL;
                            n_tx    = FLAG_BYTE[0];
                            n_cnt   = 5'd1;
                            n_ones  = '0;
                            n_eom   = 1'b0;
                        end else begin
                            b      = ~crc[cnt[3:0]];
                            n_tx   = b;
                            n_ones = b ? ones + 3'd1 : 3'd0;
                            n_cnt  = cnt + 5'd1;
                        end
                    end
                    ST_TRANSP: begin
                        if (cnt == 5'd8) begin
                            if (!fifo_empty) begin
                                fifo_pop = 1'b1;
                                n_sh     = fifo_head;
                                n_tx     = fifo_head[0];
                                n_cnt    = 5'd1;
                                n_irq    = last_byte;
                            end else if (eom) begin
                                n_state = ST_FILL;
                                n_tx    = FLAG_BYTE[0];
                                n_cnt   = 5'd1;
                                n_eom   = 1'b0;
                            end else begin
                                n_state = ST_ABORT;
                                n_tx    = 1'b1;
                                n_cnt   = 5'd1;
                            end
                        end else begin
                            n_tx  = shreg[cnt[2:0]];
                            n_cnt = cnt + 5'd1;
                        end
                    end
                    ST_ABORT: begin
                        if (cnt == 5'(ABORT_ONES)) begin
                            n_state = ST_FILL;
                            n_tx    = FLAG_BYTE[0];
                            n_cnt   = 5'd1;
                            n_ones  = '0;
                        end else begin
                            n_tx  = 1'b1;
                            n_cnt = cnt + 5'd1;
                        end
                    end
                    default: begin
                        n_state = ST_FILL;
                        n_cnt   = 5'd8;
                    end
                endcase
                if ((exec.frm || exec.trn) &&
                    (n_state == ST_FILL || n_state == ST_ABORT)) begin
                    n_go_frm = exec.frm;
                    n_go_trn = !exec.frm;
                end
                if (exec.eom) n_eom = 1'b1;
            end
        end
    end

    assign tx_bit = tx_q;
    assign irq    = irq_q;
endmodule

// File: rtl/hdlc_cmd_tx.sv
module hdlc_cmd_tx
    import hdlc_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       cmd_wr,
    input  logic [3:0] cmd_sel,
    output logic       cmd_busy,
    output logic       pool_irq,
    output logic       tx_bit
);
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    cmd_t             exec;
    logic [7:0]       fifo_head;
    logic             fifo_empty, fifo_full;
    logic [LVL_W-1:0] fifo_level;
    logic             fifo_pop, fifo_clr;

    hdlc_tx_cmd u_cmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_wr (cmd_wr),
        .cmd_in (cmd_t'(cmd_sel)),
        .tick   (bit_en),
        .busy   (cmd_busy),
        .exec   (exec)
    );

    hdlc_tx_fifo #(.DEPTH(FIFO_DEPTH), .W(8), .LW(LVL_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (fifo_clr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (fifo_pop),
        .head    (fifo_head),
        .empty   (fifo_empty),
        .full    (fifo_full),
        .level   (fifo_level)
    );

    hdlc_tx_engine #(.LW(LVL_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (bit_en),
        .exec       (exec),
        .fifo_head  (fifo_head),
        .fifo_empty (fifo_empty),
        .fifo_level (fifo_level),
        .fifo_pop   (fifo_pop),
        .fifo_clr   (fifo_clr),
        .tx_bit     (tx_bit),
        .irq        (pool_irq)
    );
endmodule

// File: rtl/hdlc_cmd_tx_chk.sv
module hdlc_cmd_tx_chk #(
    parameter int DEPTH = 32,
    parameter int LW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bit_en,
    input logic          cmd_wr,
    input logic [3:0]    cmd_sel,
    input logic          cmd_busy,
    input logic          pool_irq,
    input logic          tx_bit,
    input logic          fifo_full,
    input logic [LW-1:0] fifo_level
);
    assert_cmd_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_sel != 4'd0 && !cmd_busy) |=> cmd_busy);

    assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_busy && !bit_en) |=> cmd_busy);

    assert_busy_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_busy) |-> $past(bit_en));

    assert_line_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit));

    assert_irq_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pool_irq |-> $past(bit_en));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |=> (fifo_level <= LW'(DEPTH)));
endmodule

bind hdlc_cmd_tx hdlc_cmd_tx_chk #(.DEPTH(FIFO_DEPTH), .LW(LVL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .cmd_wr     (cmd_wr),
    .cmd_sel    (cmd_sel),
    .cmd_busy   (cmd_busy),
    .pool_irq   (pool_irq),
    .tx_bit     (tx_bit),
    .fifo_full  (fifo_full),
    .fifo_level (fifo_level)
);

// File: tb/hdlc_cmd_tx_tb.sv
module hdlc_cmd_tx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       cmd_wr = 1'b0;
    logic [3:0] cmd_sel = 4'h0;
    logic       cmd_busy, pool_irq, tx_bit;

    localparam logic [3:0] C_RST = 4'b1000;
    localparam logic [3:0] C_FRM = 4'b0100;
    localparam logic [3:0] C_TRN = 4'b0010;
    localparam logic [3:0] C_EOM = 4'b0001;

    hdlc_cmd_tx u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .wr_en(wr_en),
        .wr_data(wr_data), .cmd_wr(cmd_wr), .cmd_sel(cmd_sel),
        .cmd_busy(cmd_busy), .pool_irq(pool_irq), .tx_bit(tx_bit)
    );

    always #2 clk = ~clk;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 1'b0;
    bit  en_run = 1'b0;
    int  ph = 0;
    bit  tick_prev = 1'b0;
    int  irq_cnt = 0;
    int  stab_err = 0;
    bit  last_tx = 1'b1;
    int  exp_q[$];
    bit  raw_mode = 1'b0;
    bit  cap0[8];
    int  cap_n = 0;
    int  ones = 0;
    bit  in_frame = 1'b0;
    bit  rxbits[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // bit enable generator: one tick every four cycles
    always @(negedge clk) begin
        bit_en <= en_run && (ph == 0);
        ph     <= (ph + 1) % 4;
    end

    always @(posedge clk) tick_prev <= bit_en && rst_n;

    // scoreboard: expected events
    function automatic logic [15:0] fcs16(input byte unsigned d[$]);
        logic [15:0] c;
        logic fb;
        c = 16'hFFFF;
        foreach (d[k]) begin
            for (int i = 0; i < 8; i++) begin
                fb = c[0] ^ d[k][i];
                c = c >> 1;
                if (fb) c = c ^ 16'h8408;
            end
        end
        return ~c;
    endfunction

    task automatic push_frame(input byte unsigned d[$], input bit with_fcs);
        logic [15:0] f;
        exp_q.push_back(d.size() + (with_fcs ? 2 : 0));
        foreach (d[k]) exp_q.push_back(int'(d[k]));
        if (with_fcs) begin
            f = fcs16(d);
            exp_q.push_back(int'(f[7:0]));
            exp_q.push_back(int'(f[15:8]));
        end
    endtask

    task automatic got_abort();
        int h;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R7", "unexpected abort on line", 1, 0);
            return;
        end
        h = exp_q.pop_front();
        if (h != -1) begin
            for (int i = 0; i < h; i++) void'(exp_q.pop_front());
            chk(1'b0, "R8", "abort where frame expected", -1, h);
        end else begin
            chk(1'b1, "R7", "abort", -1, -1);
        end
    endtask

    task automatic got_frame();
        int h;
        int nb;
        int bad;
        int v;
        if (rxbits.size() % 8 != 0) begin
            chk(1'b0, "R4", "frame bit length not byte multiple", rxbits.size(), 0);
            return;
        end
        nb = rxbits.size() / 8;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R3", "unexpected frame, bytes", nb, 0);
            return;
        end
        h = exp_q.pop_front();
        if (h == -1) begin
            chk(1'b0, "R7", "frame where abort expected, bytes", nb, -1);
            return;
        end
        bad = (nb != h) ? 1 : 0;
        for (int k = 0; k < h; k++) begin
            int e;
            e = exp_q.pop_front();
            v = 0;
            if (k < nb) for (int i = 0; i < 8; i++) v |= int'(rxbits[k*8+i]) << i;
            if (k < nb && v != e) begin
                bad = 1;
                $display("FAIL R3/R5: byte %0d actual=%0d expected=%0d", k, v, e);
            end
        end
        chk(bad == 0, "R3", "frame length", nb, h);
    endtask

    task automatic rx_bit(input bit bv);
        if (cap_n < 8) cap0[cap_n] = bv;
        cap_n++;
        if (bv) begin
            ones++;
            if (ones <= 5) rxbits.push_back(1'b1);
            if (ones == 7) begin
                if (in_frame) got_abort();
                in_frame = 1'b0;
                rxbits.delete();
            end
        end else begin
            if (ones == 6) begin
                for (int i = 0; i < 6; i++) if (rxbits.size() > 0) void'(rxbits.pop_back());
                if (in_frame && rxbits.size() > 0) got_frame();
                rxbits.delete();
                in_frame = 1'b1;
            end else if (ones == 5 && !raw_mode) begin
                // inserted zero removed
            end else begin
                rxbits.push_back(1'b0);
            end
            ones = 0;
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (pool_irq) irq_cnt++;
            if (tick_prev) rx_bit(tx_bit);
            else if (tx_bit != last_tx) stab_err++;
            last_tx = tx_bit;
        end
    end

    // driver tasks
    task automatic wr_byte(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic raw_cmd(input logic [3:0] s);
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_sel = s;
        @(negedge clk);
        cmd_wr = 1'b0;
        cmd_sel = 4'h0;
    endtask

    task automatic issue_cmd(input logic [3:0] s);
        int t;
        t = 0;
        @(negedge clk);
        while (cmd_busy && t < 100) begin
            @(negedge clk);
            t++;
        end
        raw_cmd(s);
    endtask

    task automatic wait_drain(input string req);
        int t;
        t = 0;
        while (exp_q.size() != 0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(exp_q.size() == 0, req, "expected events left", exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * 4) @(negedge clk);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        byte unsigned d[$];
        int irq0;
        int t;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_bit == 1'b1, "R1", "tx_bit after reset", tx_bit, 1);
        chk(cmd_busy == 1'b0, "R1", "cmd_busy after reset", cmd_busy, 0);
        chk(pool_irq == 1'b0, "R1", "pool_irq after reset", pool_irq, 0);

        en_run = 1'b1;
        wait_ticks(40);
        begin
            int fl;
            fl = 0;
            for (int i = 0; i < 8; i++) fl |= int'(cap0[i]) << i;
            chk(fl == 8'h7E, "R1", "first idle byte on line", fl, 8'h7E);
        end

        // R3 R4 R5: single block with stuffing-prone data
        irq0 = irq_cnt;
        d = '{8'h12, 8'h7E, 8'hFF};
        foreach (d[k]) wr_byte(d[k]);
        push_frame(d, 1'b1);
        issue_cmd(C_FRM | C_EOM);
        wait_drain("R3");
        chk(irq_cnt == irq0, "R9", "no refill pulse when end already set", irq_cnt - irq0, 0);

        // R9: two-block message
        irq0 = irq_cnt;
        d = '{8'h01, 8'h02, 8'h03, 8'h04, 8'hAA, 8'hBB, 8'hCC};
        push_frame(d, 1'b1);
        for (int k = 0; k < 4; k++) wr_byte(d[k]);
        issue_cmd(C_FRM);
        t = 0;
        while (irq_cnt == irq0 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk(irq_cnt == irq0 + 1, "R9", "refill pulse after first block", irq_cnt - irq0, 1);
        for (int k = 4; k < 7; k++) wr_byte(d[k]);
        issue_cmd(C_EOM);
        wait_drain("R9");
        chk(irq_cnt == irq0 + 1, "R9", "refill pulses for whole message", irq_cnt - irq0, 1);

        // R7: underrun
        irq0 = irq_cnt;
        exp_q.push_back(-1);
        wr_byte(8'h55);
        wr_byte(8'h66);
        issue_cmd(C_FRM);
        wait_drain("R7");
        chk(irq_cnt == irq0 + 1, "R7", "pulse before underrun", irq_cnt - irq0, 1);

        // R6: transparent, five ones then zero must not be stuffed
        raw_mode = 1'b1;
        d = '{8'hF8, 8'h00, 8'hA5};
        foreach (d[k]) wr_byte(d[k]);
        push_frame(d, 1'b0);
        issue_cmd(C_TRN | C_EOM);
        wait_drain("R6");
        wait_ticks(2);
        raw_mode = 1'b0;

        // R8: reset during a long frame, then queue must be empty
        irq0 = irq_cnt;
        for (int k = 0; k < 20; k++) wr_byte(8'(k * 7 + 1));
        exp_q.push_back(-1);
        issue_cmd(C_FRM | C_EOM);
        wait_ticks(60);
        issue_cmd(C_RST);
        wait_drain("R8");
        chk(irq_cnt == irq0 + 1, "R8", "pulse on reset completion", irq_cnt - irq0, 1);
        d = '{8'h3C, 8'hC3};
        foreach (d[k]) wr_byte(d[k]);
        push_frame(d, 1'b1);
        issue_cmd(C_FRM | C_EOM);
        wait_drain("R8");

        // R10: 34 writes, only 32 kept
        d.delete();
        for (int k = 0; k < 34; k++) begin
            wr_byte(8'(8'h40 + k));
            if (k < 32) d.push_back(8'(8'h40 + k));
        end
        push_frame(d, 1'b1);
        issue_cmd(C_FRM | C_EOM);
        wait_drain("R10");

        // R2: command blocked without bit enable; second command dropped
        en_run = 1'b0;
        wait_ticks(3);
        raw_cmd(C_RST);
        repeat (20) @(negedge clk);
        chk(cmd_busy == 1'b1, "R2", "busy while no bit enable", cmd_busy, 1);
        raw_cmd(C_FRM);
        chk(cmd_busy == 1'b1, "R2", "busy after refused write", cmd_busy, 1);
        exp_q.push_back(-1);
        en_run = 1'b1;
        repeat (12) @(negedge clk);
        chk(cmd_busy == 1'b0, "R2", "busy cleared after execution", cmd_busy, 0);
        wait_drain("R2");
        wr_byte(8'h11);
        wr_byte(8'h22);
        wait_ticks(40);
        chk(exp_q.size() == 0, "R2", "dropped start caused no event", exp_q.size(), 0);
        d = '{8'h11, 8'h22};
        push_frame(d, 1'b1);
        issue_cmd(C_FRM | C_EOM);
        wait_drain("R2");

        chk(stab_err == 0, "R11", "line changes outside bit enable", stab_err, 0);
        finish_run();
    end
endmodule